// File: doc/BRIEF.md
# Wide Bus Chain Byte Holder

This block sits between a byte stream on the memory side and a 16-bit word bus on the peripheral side. It serves both directions, one at a time, chosen by a direction input. A second input selects wide mode, where both byte lanes carry data, or narrow mode, where only the low lane does. In wide mode the block packs memory bytes into words on send and unpacks words into bytes on receive. The earlier byte in memory order always travels on the low lane.

Transfers are split into segments, and a segment may be marked as chained to the next one. When a chained segment leaves a single byte over, that byte is kept inside the block and is not pushed to the far side. On send, the kept byte waits to be joined with the first byte of the next send segment. On receive, the unused high byte of the last word is kept back from memory and is handed out ahead of the next received word. Each direction has its own storage byte and its own status flag. Software can clear either flag, and the flags can be read for recovery.

Top module: `wide_chain_byte_holder`

## Requirements
- R1: In wide send, when the last byte of a chained segment has no partner, that byte is not put on the bus. `send_hold` rises on the next clock, and only such an acceptance can raise it.
- R2: In wide send, when the last byte of a non-chained segment has no partner, it goes out as one word with the byte on bits 7:0 and zero on bits 15:8. `send_hold` stays low.
- R3: When `send_hold` is set, the first byte of the next wide send is joined with the kept byte into one word: kept byte on bits 7:0, new byte on bits 15:8. This happens whether the new segment is chained or not. Packing then starts again from the second byte of that segment.
- R4: `send_hold` goes low once the bus has accepted the joined word.
- R5: `send_hold` goes low on the clock after any word is accepted on the receive bus port, or after any byte is accepted in narrow send.
- R6: A high `clr_send_hold` or `clr_recv_hold` forces the matching flag low on the next clock. This wins over a set in the same cycle.
- R7: In wide receive, a word marked last and odd (`bus_rx_odd`=1: only bits 7:0 belong to the segment) gives memory only its low byte. If the word is also chained, bits 15:8 are kept and `recv_hold` rises. If it is not chained, bits 15:8 are dropped.
- R8: While `recv_hold` is set and a wide receive word is offered, the bus port holds off. The kept byte goes to memory first, and `recv_hold` drops when memory accepts it.
- R9: In narrow mode a sent byte becomes a word with zero on bits 15:8, and a received word gives only its bits 7:0. Narrow receive leaves `recv_hold` and its kept byte untouched.
- R10: While a bus word waits for acceptance, `mem_tx_ready` is low and the word stays stable. While a memory byte waits for acceptance, it stays stable. No byte is lost or repeated under backpressure.
- R11: In wide mode, two bytes accepted in a row within a segment form one word with the earlier byte on bits 7:0. A received word gives bits 7:0 first, then bits 15:8.
- R12: After reset both flags are low and both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_dir | input | 1 | 0 = send (memory to bus), 1 = receive (bus to memory) |
| wide_en | input | 1 | 1 = both byte lanes used, 0 = low lane only |
| clr_send_hold | input | 1 | Clears the send flag |
| clr_recv_hold | input | 1 | Clears the receive flag |
| mem_tx_valid | input | 1 | Memory byte offered for send |
| mem_tx_ready | output | 1 | Block accepts the memory byte |
| mem_tx_data | input | 8 | Memory byte |
| mem_tx_last | input | 1 | Byte ends its segment |
| mem_tx_chain | input | 1 | Segment is chained |
| bus_tx_valid | output | 1 | Word offered to the bus |
| bus_tx_ready | input | 1 | Bus accepts the word |
| bus_tx_data | output | 16 | Outgoing word |
| bus_rx_valid | input | 1 | Word offered by the bus |
| bus_rx_ready | output | 1 | Block accepts the bus word |
| bus_rx_data | input | 16 | Incoming word |
| bus_rx_last | input | 1 | Word ends its segment |
| bus_rx_odd | input | 1 | With last: only bits 7:0 belong to the segment |
| bus_rx_chain | input | 1 | Segment is chained |
| mem_rx_valid | output | 1 | Byte offered to memory |
| mem_rx_ready | input | 1 | Memory accepts the byte |
| mem_rx_data | output | 8 | Byte to memory |
| send_hold | output | 1 | A send byte is being kept |
| recv_hold | output | 1 | A receive byte is being kept |

## Verification
The assertions assume three things about the inputs. Direction and width change only between segments, while nothing is in flight. A bus word, once offered, stays offered until it is taken. The receive stability check depends on this, because the kept byte is only presented while a receive word is waiting. The stimulus sets modes only after the scoreboard queues have drained. Every driver holds its valid and data from its drive point until the ready it waits on is seen. Backpressure comes only from the ready inputs, which are free to toggle each cycle.

// File: rtl/wcb_pkg.sv
`timescale 1ns/1ps
package wcb_pkg;
    localparam int LANES = 2;

    typedef enum logic {
        DIR_SEND = 1'b0,
        DIR_RECV = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/wcb_tx_path.sv
`timescale 1ns/1ps
module wcb_tx_path #(
    parameter  int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              wide,
    input  logic              sw_clr,
    input  logic              ext_clr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_chain,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              hold
);
    typedef struct packed {
        logic [BYTE_W-1:0] lo_byte;
        logic              lo_vld;
        logic [BYTE_W-1:0] kept_byte;
        logic              kept;
        logic [WORD_W-1:0] word;
        logic              word_vld;
        logic              word_pair;
    } tx_state_t;

    tx_state_t s_q, s_d;
    logic      take;

    always_comb begin
        s_d      = s_q;
        in_ready = active && (!s_q.word_vld || (out_ready && !s_q.word_pair));
        take     = in_valid && in_ready;

        if (s_q.word_vld && out_ready) begin
            s_d.word_vld = 1'b0;
            if (s_q.word_pair) begin
                s_d.kept      = 1'b0;
                s_d.word_pair = 1'b0;
            end
        end

        if (take) begin
            if (!wide) begin
                s_d.word      = {{BYTE_W{1'b0}}, in_data};
                s_d.word_vld  = 1'b1;
                s_d.word_pair = 1'b0;
                s_d.kept      = 1'b0;
            end else if (s_q.kept && !s_q.lo_vld) begin
                s_d.word      = {in_data, s_q.kept_byte};
                s_d.word_vld  = 1'b1;
                s_d.word_pair = 1'b1;
            end else if (s_q.lo_vld) begin
                s_d.word      = {in_data, s_q.lo_byte};
                s_d.word_vld  = 1'b1;
                s_d.word_pair = 1'b0;
                s_d.lo_vld    = 1'b0;
            end else if (in_last) begin
                if (in_chain) begin
                    s_d.kept_byte = in_data;
                    s_d.kept      = 1'b1;
                end else begin
                    s_d.word      = {{BYTE_W{1'b0}}, in_data};
                    s_d.word_vld  = 1'b1;
                    s_d.word_pair = 1'b0;
                end
            end else begin
                s_d.lo_byte = in_data;
                s_d.lo_vld  = 1'b1;
            end
        end

        if (sw_clr || ext_clr) begin
            s_d.kept = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.word_vld;
    assign out_data  = s_q.word;
    assign hold      = s_q.kept;
endmodule

// File: rtl/wcb_rx_path.sv
`timescale 1ns/1ps
module wcb_rx_path #(
    parameter  int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              wide,
    input  logic              sw_clr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_odd,
    input  logic              in_chain,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              hold,
    output logic              word_taken
);
    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [1:0]        rem;
        logic [BYTE_W-1:0] kept_byte;
        logic              kept;
    } rx_state_t;

    rx_state_t s_q, s_d;
    logic      deliver;
    logic      take;

    always_comb begin
        s_d       = s_q;
        deliver   = active && wide && s_q.kept && in_valid && (s_q.rem == 2'd0);
        out_valid = deliver || (s_q.rem != 2'd0);
        out_data  = deliver ? s_q.kept_byte : s_q.shreg[BYTE_W-1:0];
        in_ready  = active && (s_q.rem == 2'd0) && !(wide && s_q.kept);
        take      = in_valid && in_ready;

        if (out_valid && out_ready) begin
            if (deliver) begin
                s_d.kept = 1'b0;
            end else begin
                s_d.shreg = {{BYTE_W{1'b0}}, s_q.shreg[WORD_W-1:BYTE_W]};
                s_d.rem   = s_q.rem - 2'd1;
            end
        end

        if (take) begin
            if (wide) begin
                s_d.shreg = in_data;
                if (in_last && in_odd) begin
                    s_d.rem = 2'd1;
                    if (in_chain) begin
                        s_d.kept_byte = in_data[WORD_W-1:BYTE_W];
                        s_d.kept      = 1'b1;
                    end
                end else begin
                    s_d.rem = 2'd2;
                end
            end else begin
                s_d.shreg = {{BYTE_W{1'b0}}, in_data[BYTE_W-1:0]};
                s_d.rem   = 2'd1;
            end
        end

        if (sw_clr) begin
            s_d.kept = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold       = s_q.kept;
    assign word_taken = take;
endmodule

// File: rtl/wide_chain_byte_holder.sv
`timescale 1ns/1ps
module wide_chain_byte_holder
    import wcb_pkg::*;
#(
    parameter  int BYTE_W = 8,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_dir,
    input  logic              wide_en,
    input  logic              clr_send_hold,
    input  logic              clr_recv_hold,
    input  logic              mem_tx_valid,
    output logic              mem_tx_ready,
    input  logic [BYTE_W-1:0] mem_tx_data,
    input  logic              mem_tx_last,
    input  logic              mem_tx_chain,
    output logic              bus_tx_valid,
    input  logic              bus_tx_ready,
    output logic [WORD_W-1:0] bus_tx_data,
    input  logic              bus_rx_valid,
    output logic              bus_rx_ready,
    input  logic [WORD_W-1:0] bus_rx_data,
    input  logic              bus_rx_last,
    input  logic              bus_rx_odd,
    input  logic              bus_rx_chain,
    output logic              mem_rx_valid,
    input  logic              mem_rx_ready,
    output logic [BYTE_W-1:0] mem_rx_data,
    output logic              send_hold,
    output logic              recv_hold
);
    logic send_active;
    logic recv_active;
    logic rx_word_taken;

    assign recv_active = (xfer_dir == logic'(DIR_RECV));
    assign send_active = !recv_active;

    wcb_tx_path #(.BYTE_W(BYTE_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (send_active),
        .wide      (wide_en),
        .sw_clr    (clr_send_hold),
        .ext_clr   (rx_word_taken),
        .in_valid  (mem_tx_valid),
        .in_ready  (mem_tx_ready),
        .in_data   (mem_tx_data),
        .in_last   (mem_tx_last),
        .in_chain  (mem_tx_chain),
        .out_valid (bus_tx_valid),
        .out_ready (bus_tx_ready),
        .out_data  (bus_tx_data),
        .hold      (send_hold)
    );

    wcb_rx_path #(.BYTE_W(BYTE_W)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (recv_active),
        .wide       (wide_en),
        .sw_clr     (clr_recv_hold),
        .in_valid   (bus_rx_valid),
        .in_ready   (bus_rx_ready),
        .in_data    (bus_rx_data),
        .in_last    (bus_rx_last),
        .in_odd     (bus_rx_odd),
        .in_chain   (bus_rx_chain),
        .out_valid  (mem_rx_valid),
        .out_ready  (mem_rx_ready),
        .out_data   (mem_rx_data),
        .hold       (recv_hold),
        .word_taken (rx_word_taken)
    );
endmodule

module wcb_chk #(
    parameter  int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_dir,
    input logic              wide_en,
    input logic              clr_send_hold,
    input logic              clr_recv_hold,
    input logic              mem_tx_valid,
    input logic              mem_tx_ready,
    input logic              mem_tx_last,
    input logic              mem_tx_chain,
    input logic              bus_tx_valid,
    input logic              bus_tx_ready,
    input logic [WORD_W-1:0] bus_tx_data,
    input logic              bus_rx_valid,
    input logic              bus_rx_ready,
    input logic              bus_rx_last,
    input logic              bus_rx_odd,
    input logic              bus_rx_chain,
    input logic              mem_rx_valid,
    input logic              mem_rx_ready,
    input logic [BYTE_W-1:0] mem_rx_data,
    input logic              send_hold,
    input logic              recv_hold
);
    // R10
    tx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tx_valid && !bus_tx_ready) |-> !mem_tx_ready);
    // R10
    tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tx_valid && !bus_tx_ready) |=> (bus_tx_valid && $stable(bus_tx_data)));
    // R10
    rx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rx_valid && !mem_rx_ready) |=> (mem_rx_valid && $stable(mem_rx_data)));
    // R6
    clr_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_send_hold |=> !send_hold);
    // R6
    clr_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_recv_hold |=> !recv_hold);
    // R5
    rx_word_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rx_valid && bus_rx_ready) |=> !send_hold);
    // R5
    narrow_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_tx_valid && mem_tx_ready && !wide_en) |=> !send_hold);
    // R1
    send_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_hold) |-> $past(mem_tx_valid && mem_tx_ready && mem_tx_last
                                   && mem_tx_chain && wide_en));
    // R7
    recv_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recv_hold) |-> $past(bus_rx_valid && bus_rx_ready && bus_rx_last
                                   && bus_rx_odd && bus_rx_chain && wide_en));
    // R8
    held_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recv_hold && wide_en && xfer_dir && bus_rx_valid) |-> !bus_rx_ready);
    // R9
    narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_tx_valid && mem_tx_ready && !wide_en)
        |=> (bus_tx_valid && (bus_tx_data[WORD_W-1:BYTE_W] == '0)));
endmodule

bind wide_chain_byte_holder wcb_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer_dir      (xfer_dir),
    .wide_en       (wide_en),
    .clr_send_hold (clr_send_hold),
    .clr_recv_hold (clr_recv_hold),
    .mem_tx_valid  (mem_tx_valid),
    .mem_tx_ready  (mem_tx_ready),
    .mem_tx_last   (mem_tx_last),
    .mem_tx_chain  (mem_tx_chain),
    .bus_tx_valid  (bus_tx_valid),
    .bus_tx_ready  (bus_tx_ready),
    .bus_tx_data   (bus_tx_data),
    .bus_rx_valid  (bus_rx_valid),
    .bus_rx_ready  (bus_rx_ready),
    .bus_rx_last   (bus_rx_last),
    .bus_rx_odd    (bus_rx_odd),
    .bus_rx_chain  (bus_rx_chain),
    .mem_rx_valid  (mem_rx_valid),
    .mem_rx_ready  (mem_rx_ready),
    .mem_rx_data   (mem_rx_data),
    .send_hold     (send_hold),
    .recv_hold     (recv_hold)
);

// File: tb/wide_chain_byte_holder_tb_top.sv
`timescale 1ns/1ps
module wide_chain_byte_holder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        xfer_dir, wide_en, clr_send_hold, clr_recv_hold;
    logic        mem_tx_valid, mem_tx_ready, mem_tx_last, mem_tx_chain;
    logic [7:0]  mem_tx_data;
    logic        bus_tx_valid, bus_tx_ready;
    logic [15:0] bus_tx_data;
    logic        bus_rx_valid, bus_rx_ready, bus_rx_last, bus_rx_odd, bus_rx_chain;
    logic [15:0] bus_rx_data;
    logic        mem_rx_valid, mem_rx_ready;
    logic [7:0]  mem_rx_data;
    logic        send_hold, recv_hold;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wide_chain_byte_holder dut_i (.*);

    logic [15:0] exp_tx[$];
    logic [7:0]  exp_rx[$];
    int          n_chk  = 0;
    int          n_fail = 0;
    string       cur_req = "R11";
    bit          bp_tx = 0, bp_rx = 0;
    int          cyc = 0;

    // reference state derived from the requirements
    bit          m_wide = 1, m_send_hold = 0, m_recv_hold = 0, m_lo_vld = 0;
    logic [7:0]  m_kept_tx, m_kept_rx, m_lo;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // ready generators for backpressure (R10)
    always @(posedge clk) begin
        #1;
        cyc++;
        bus_tx_ready = !bp_tx || (cyc % 3 == 0);
        mem_rx_ready = !bp_rx || (cyc % 2 == 0);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_tx_valid && bus_tx_ready) begin
                if (exp_tx.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL %s: unexpected bus word actual 0x%0h expected none", cur_req, bus_tx_data);
                end else begin
                    check(cur_req, bus_tx_data, exp_tx.pop_front());
                end
            end
            if (mem_rx_valid && mem_rx_ready) begin
                if (exp_rx.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL %s: unexpected memory byte actual 0x%0h expected none", cur_req, mem_rx_data);
                end else begin
                    check(cur_req, mem_rx_data, exp_rx.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    task automatic set_mode(logic dir, logic wide);
        @(posedge clk); #1;
        xfer_dir = dir; wide_en = wide; m_wide = wide;
    endtask

    task automatic send_byte(logic [7:0] b, bit last, bit chain);
        if (!m_wide) begin
            exp_tx.push_back({8'h00, b}); m_send_hold = 0;
        end else if (m_send_hold && !m_lo_vld) begin
            exp_tx.push_back({b, m_kept_tx}); m_send_hold = 0;
        end else if (m_lo_vld) begin
            exp_tx.push_back({b, m_lo}); m_lo_vld = 0;
        end else if (last) begin
            if (chain) begin m_kept_tx = b; m_send_hold = 1; end
            else exp_tx.push_back({8'h00, b});
        end else begin
            m_lo = b; m_lo_vld = 1;
        end
        @(posedge clk); #1;
        mem_tx_valid = 1; mem_tx_data = b; mem_tx_last = last; mem_tx_chain = chain;
        forever begin @(negedge clk); if (mem_tx_ready) break; end
        @(posedge clk); #1;
        mem_tx_valid = 0;
    endtask

    task automatic send_seg(int n, logic [7:0] base, bit chain);
        for (int i = 0; i < n; i++) send_byte(base + 8'(i), i == n - 1, chain);
    endtask

    task automatic recv_word(logic [15:0] w, bit last, bit odd, bit chain);
        m_send_hold = 0;
        if (m_wide) begin
            if (m_recv_hold) begin exp_rx.push_back(m_kept_rx); m_recv_hold = 0; end
            exp_rx.push_back(w[7:0]);
            if (!(last && odd)) exp_rx.push_back(w[15:8]);
            else if (chain) begin m_kept_rx = w[15:8]; m_recv_hold = 1; end
        end else begin
            exp_rx.push_back(w[7:0]);
        end
        @(posedge clk); #1;
        bus_rx_valid = 1; bus_rx_data = w; bus_rx_last = last; bus_rx_odd = odd; bus_rx_chain = chain;
        forever begin @(negedge clk); if (bus_rx_ready) break; end
        @(posedge clk); #1;
        bus_rx_valid = 0;
    endtask

    task automatic drain();
        int t = 0;
        while ((exp_tx.size() != 0 || exp_rx.size() != 0) && t < 2000) begin
            @(posedge clk); t++;
        end
        if (t >= 2000) begin
            n_chk++; n_fail++;
            $display("FAIL %s: queues not drained actual %0d expected 0", cur_req, exp_tx.size() + exp_rx.size());
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_flags(string req);
        check(req, send_hold, m_send_hold);
        check(req, recv_hold, m_recv_hold);
    endtask

    task automatic pulse_clr(bit tx_side);
        @(posedge clk); #1;
        if (tx_side) begin clr_send_hold = 1; m_send_hold = 0; end
        else begin clr_recv_hold = 1; m_recv_hold = 0; end
        @(posedge clk); #1;
        clr_send_hold = 0; clr_recv_hold = 0;
    endtask

    initial begin
        rst_n = 0; xfer_dir = 0; wide_en = 1; clr_send_hold = 0; clr_recv_hold = 0;
        mem_tx_valid = 0; mem_tx_data = 0; mem_tx_last = 0; mem_tx_chain = 0;
        bus_rx_valid = 0; bus_rx_data = 0; bus_rx_last = 0; bus_rx_odd = 0; bus_rx_chain = 0;
        bus_tx_ready = 1; mem_rx_ready = 1;
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        check("R12", send_hold, 0);
        check("R12", recv_hold, 0);
        check("R12", bus_tx_valid, 0);
        check("R12", mem_rx_valid, 0);

        // R11 even wide send packs low lane first
        cur_req = "R11"; send_seg(4, 8'h10, 0); drain(); check_flags("R11");
        // R2 odd normal end is padded, no hold
        cur_req = "R2"; send_seg(3, 8'h20, 0); drain(); check_flags("R2");
        // R1 odd chained end is kept, nothing extra on the bus
        cur_req = "R1"; send_seg(3, 8'h30, 1); drain(); check_flags("R1");
        // R3 pairing with a normal segment, then packing resumes; R4 flag drops
        cur_req = "R3"; send_seg(3, 8'h40, 0); drain(); check_flags("R4");
        // R3 single-byte chained then two-byte chained: pair then keep again
        cur_req = "R3"; send_seg(1, 8'h50, 1); send_seg(2, 8'h58, 1); drain(); check_flags("R3");
        // R6 software clear of the send flag, next send packs normally
        cur_req = "R6"; pulse_clr(1); @(negedge clk); check_flags("R6");
        send_seg(2, 8'h60, 0); drain(); check_flags("R6");
        // R5 a received word clears the send flag
        cur_req = "R5"; send_seg(1, 8'h70, 1); drain(); check_flags("R5");
        set_mode(1, 1); recv_word(16'hA1B2, 1, 0, 0); drain(); check_flags("R5");
        set_mode(0, 1); send_seg(2, 8'h74, 0); drain();
        // R5 and R9 narrow send clears the flag and pads
        cur_req = "R9"; send_seg(1, 8'h78, 1); drain(); check_flags("R5");
        set_mode(0, 0); send_seg(2, 8'h7C, 0); drain(); check_flags("R9");
        // R10 send under bus backpressure, with keep and pairing
        cur_req = "R10"; set_mode(0, 1); bp_tx = 1;
        send_seg(7, 8'h80, 1); send_seg(5, 8'h90, 0); drain(); check_flags("R10");
        bp_tx = 0;
        // R7 wide receive chained odd end keeps the high byte
        cur_req = "R7"; set_mode(1, 1);
        recv_word(16'h0201, 0, 0, 1); recv_word(16'h0403, 0, 0, 1); recv_word(16'h0605, 1, 1, 1);
        drain(); check_flags("R7");
        // R8 kept byte delivered first, flag drops
        cur_req = "R8"; recv_word(16'h0807, 1, 0, 0); drain(); check_flags("R8");
        // R7 normal odd end drops the high byte
        cur_req = "R7"; recv_word(16'h0A09, 1, 1, 0); drain(); check_flags("R7");
        // R9 narrow receive leaves the kept byte alone
        cur_req = "R9"; recv_word(16'h0C0B, 1, 1, 1); drain();
        set_mode(1, 0); recv_word(16'h0E0D, 1, 0, 0); drain(); check_flags("R9");
        // R6 software clear of the receive flag, kept byte is not delivered
        cur_req = "R6"; pulse_clr(0); @(negedge clk); check_flags("R6");
        set_mode(1, 1); recv_word(16'h1211, 1, 0, 0); drain(); check_flags("R6");
        // R10 receive under memory backpressure with a kept byte
        cur_req = "R10"; bp_rx = 1;
        recv_word(16'h2221, 0, 0, 1); recv_word(16'h2423, 1, 1, 1);
        recv_word(16'h2625, 1, 0, 0); drain(); check_flags("R10");
        bp_rx = 0;
        summary();
    end
endmodule